// File: doc/BRIEF.md
# Coherence Line Merge Buffer

This block keeps one cache line while a coherence transaction is in flight. It holds the line, a per-byte write mask, a dirty flag, a cached flag, a flag that shows memory data has arrived, and the identity of the agent that last supplied the data. A transaction opens with a start event that carries the current backing copy of the line and, for write-through or atomic requests, a payload with its byte mask. Memory fills and probe responses then arrive one per cycle, and the buffer merges each of them under fixed precedence rules. A finalise event closes the transaction and produces the line, with byte enables, that must be committed to backing storage.

Write-through bytes always win over any other data. Data that is already dirty is never replaced by a memory fill. A dirty probe that arrives during a write-through is folded in underneath the write-through bytes, and the mask is then widened to the full line. The atomic operation is a placeholder: a byte-wise add, modulo 256, of the stored byte and the operand byte on masked bytes.

Top module: `line_merge_unit`

## Requirements
- R1: A start event opens a transaction (active_o high) and sets sender_o to start_sender_i, clears cached_o and memdata_o, and keeps start_data_i as the operand. The kind code is 0 for a plain read, 1 for a write-through and 2 for an atomic, and 3 is treated as 0. A plain start loads start_line_i, a zero mask and a clean line. A write-through start loads start_line_i with each byte i replaced by start_data_i bits [8i+7:8i] when start_mask_i bit i is 1, takes start_mask_i as the mask and marks the line dirty. An atomic start loads start_line_i and start_mask_i and leaves the line clean.
- R2: During a write-through, a memory fill leaves the line unchanged. In any other kind, a fill replaces the line only when it is clean.
- R3: Every memory fill in an open transaction sets memdata_o.
- R4: A dirty probe response during a write-through produces the probe data with every masked byte taken from the buffered line, and sets mask_o to all ones. The dirty flag and the sender are kept.
- R5: A dirty probe response in a plain or atomic transaction with a clean line loads the probe data, sets dirty_o and records prb_sender_i in sender_o.
- R6: A dirty probe response in a plain transaction with a dirty line leaves the line unchanged, and raises mismatch_o for one cycle when the probe data differs from the line. In an atomic transaction with a dirty line, such a probe has no effect and raises no mismatch.
- R7: Any probe response with prb_hit_i set sets cached_o. A probe response whose dirty flag is clear never changes the line.
- R8: Finalising a write-through commits the buffered line with commit_be_o equal to the mask.
- R9: Finalising an atomic commits a full line (all enables set). Each masked byte is fin_store_i byte plus operand byte, modulo 256, and each other byte is the buffered byte.
- R10: Finalising a plain transaction commits the full line when it is clean, and commits nothing when it is dirty.
- R11: Fill, probe and finalise events with no open transaction have no effect. A finalise closes the transaction.
- R12: After reset, every output is zero.
- R13: State outputs change at the clock edge that accepts an event. commit_valid_o, commit_be_o and commit_data_o are valid for exactly the one cycle after the finalise edge, and are zero in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Open a transaction |
| start_kind_i | input | 2 | 0 plain, 1 write-through, 2 atomic |
| start_line_i | input | 512 | Current backing copy of the line |
| start_data_i | input | 512 | Write-through payload or atomic operand |
| start_mask_i | input | 64 | Payload byte mask, bit i covers byte i |
| start_sender_i | input | 4 | Requesting agent |
| fill_valid_i | input | 1 | Memory fill arrives |
| fill_data_i | input | 512 | Memory fill data |
| prb_valid_i | input | 1 | Probe response arrives |
| prb_data_i | input | 512 | Probe response data |
| prb_dirty_i | input | 1 | Probe data is dirty |
| prb_hit_i | input | 1 | Responder holds a copy |
| prb_sender_i | input | 4 | Responding agent |
| fin_valid_i | input | 1 | Finalise the transaction |
| fin_store_i | input | 512 | Backing line used by the atomic operation |
| active_o | output | 1 | Transaction open |
| kind_o | output | 2 | Decoded kind |
| line_o | output | 512 | Buffered line |
| mask_o | output | 64 | Byte mask |
| dirty_o | output | 1 | Line dirty |
| cached_o | output | 1 | Some responder holds a copy |
| memdata_o | output | 1 | Memory fill seen |
| sender_o | output | 4 | Last data supplier |
| mismatch_o | output | 1 | Dirty data disagreement pulse |
| commit_valid_o | output | 1 | Commit pulse |
| commit_be_o | output | 64 | Commit byte enables |
| commit_data_o | output | 512 | Commit line |

## Verification
The assertions assume that at most one of the four event valids is high in any cycle, and they check that assumption directly. The merge rules are only defined for single events. The random stimulus picks exactly one event, or an idle cycle, per step. Probe data is often copied from the bench's own model of the line, so that both matching and differing dirty probes occur. Events are also sent on purpose with no transaction open, to reach the ignore rules.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  localparam int unsigned LMU_BYTE_W = 8;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_WT     = 2'd1,
    KIND_ATOMIC = 2'd2
  } lmu_kind_e;

  function automatic lmu_kind_e lmu_decode_kind(input logic [1:0] raw);
    case (raw)
      2'd1:    return KIND_WT;
      2'd2:    return KIND_ATOMIC;
      default: return KIND_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/lmu_byte_merge.sv
module lmu_byte_merge #(
  parameter int unsigned NBYTES = 64
) (
  input  logic [NBYTES-1:0]   sel_i,
  input  logic [NBYTES*8-1:0] pick_i,
  input  logic [NBYTES*8-1:0] base_i,
  output logic [NBYTES*8-1:0] merged_o
);
  // byte i comes from pick_i when sel_i[i] is set, else from base_i
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged_o[b*8 +: 8] = sel_i[b] ? pick_i[b*8 +: 8] : base_i[b*8 +: 8];
  end
endmodule

// File: rtl/lmu_atomic_alu.sv
module lmu_atomic_alu #(
  parameter int unsigned NBYTES = 64
) (
  input  logic [NBYTES-1:0]   mask_i,
  input  logic [NBYTES*8-1:0] store_i,
  input  logic [NBYTES*8-1:0] oper_i,
  input  logic [NBYTES*8-1:0] keep_i,
  output logic [NBYTES*8-1:0] result_o
);
  // placeholder read-modify-write: byte add modulo 256
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] sum;
    assign sum = store_i[b*8 +: 8] + oper_i[b*8 +: 8];
    assign result_o[b*8 +: 8] = mask_i[b] ? sum : keep_i[b*8 +: 8];
  end
endmodule

// File: rtl/lmu_commit_sel.sv
module lmu_commit_sel
  import lmu_pkg::*;
#(
  parameter int unsigned NBYTES = 64
) (
  input  lmu_kind_e           kind_i,
  input  logic                dirty_i,
  input  logic [NBYTES-1:0]   mask_i,
  input  logic [NBYTES*8-1:0] line_i,
  input  logic [NBYTES*8-1:0] atomic_i,
  output logic                valid_o,
  output logic [NBYTES-1:0]   be_o,
  output logic [NBYTES*8-1:0] data_o
);
  always_comb begin
    valid_o = 1'b0;
    be_o    = '0;
    data_o  = '0;
    case (kind_i)
      KIND_WT: begin
        valid_o = 1'b1;
        be_o    = mask_i;
        data_o  = line_i;
      end
      KIND_ATOMIC: begin
        valid_o = 1'b1;
        be_o    = '1;
        data_o  = atomic_i;
      end
      default: begin
        if (!dirty_i) begin
          valid_o = 1'b1;
          be_o    = '1;
          data_o  = line_i;
        end
      end
    endcase
  end
endmodule

// File: rtl/line_merge_unit.sv
module line_merge_unit
  import lmu_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned SENDER_W   = 4,
  localparam int unsigned LINE_W    = LINE_BYTES * LMU_BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_valid_i,
  input  logic [1:0]            start_kind_i,
  input  logic [LINE_W-1:0]     start_line_i,
  input  logic [LINE_W-1:0]     start_data_i,
  input  logic [LINE_BYTES-1:0] start_mask_i,
  input  logic [SENDER_W-1:0]   start_sender_i,
  input  logic                  fill_valid_i,
  input  logic [LINE_W-1:0]     fill_data_i,
  input  logic                  prb_valid_i,
  input  logic [LINE_W-1:0]     prb_data_i,
  input  logic                  prb_dirty_i,
  input  logic                  prb_hit_i,
  input  logic [SENDER_W-1:0]   prb_sender_i,
  input  logic                  fin_valid_i,
  input  logic [LINE_W-1:0]     fin_store_i,
  output logic                  active_o,
  output logic [1:0]            kind_o,
  output logic [LINE_W-1:0]     line_o,
  output logic [LINE_BYTES-1:0] mask_o,
  output logic                  dirty_o,
  output logic                  cached_o,
  output logic                  memdata_o,
  output logic [SENDER_W-1:0]   sender_o,
  output logic                  mismatch_o,
  output logic                  commit_valid_o,
  output logic [LINE_BYTES-1:0] commit_be_o,
  output logic [LINE_W-1:0]     commit_data_o
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // state
  logic                  active_q, active_d;
  lmu_kind_e             kind_q, kind_d;
  logic [LINE_W-1:0]     line_q, line_d;
  logic [LINE_W-1:0]     oper_q;
  logic [LINE_BYTES-1:0] mask_q, mask_d;
  logic                  dirty_q, dirty_d;
  logic                  cached_q, cached_d;
  logic                  memd_q, memd_d;
  logic [SENDER_W-1:0]   sender_q, sender_d;
  logic                  mism_q, mism_d;
  logic                  cv_q, cv_d;
  logic [LINE_BYTES-1:0] cbe_q, cbe_d;
  logic [LINE_W-1:0]     cdata_q, cdata_d;

  lmu_kind_e start_kind;
  assign start_kind = lmu_decode_kind(start_kind_i);

  // datapath
  logic [LINE_W-1:0] wt_start_line;
  logic [LINE_W-1:0] prb_wt_line;
  logic [LINE_W-1:0] atomic_line;
  logic              sel_valid;
  logic [LINE_BYTES-1:0] sel_be;
  logic [LINE_W-1:0] sel_data;

  lmu_byte_merge #(.NBYTES(LINE_BYTES)) u_start_merge (
    .sel_i    (start_mask_i),
    .pick_i   (start_data_i),
    .base_i   (start_line_i),
    .merged_o (wt_start_line)
  );

  // write-through bytes held in the buffer sit on top of probe data
  lmu_byte_merge #(.NBYTES(LINE_BYTES)) u_probe_merge (
    .sel_i    (mask_q),
    .pick_i   (line_q),
    .base_i   (prb_data_i),
    .merged_o (prb_wt_line)
  );

  lmu_atomic_alu #(.NBYTES(LINE_BYTES)) u_alu (
    .mask_i   (mask_q),
    .store_i  (fin_store_i),
    .oper_i   (oper_q),
    .keep_i   (line_q),
    .result_o (atomic_line)
  );

  lmu_commit_sel #(.NBYTES(LINE_BYTES)) u_commit (
    .kind_i   (kind_q),
    .dirty_i  (dirty_q),
    .mask_i   (mask_q),
    .line_i   (line_q),
    .atomic_i (atomic_line),
    .valid_o  (sel_valid),
    .be_o     (sel_be),
    .data_o   (sel_data)
  );

  // clock enables
  logic ev_en, oper_en;
  assign ev_en   = start_valid_i | (active_q & (fill_valid_i | prb_valid_i | fin_valid_i));
  assign oper_en = start_valid_i;

  // next state
  always_comb begin
    active_d = active_q;
    kind_d   = kind_q;
    line_d   = line_q;
    mask_d   = mask_q;
    dirty_d  = dirty_q;
    cached_d = cached_q;
    memd_d   = memd_q;
    sender_d = sender_q;
    mism_d   = 1'b0;
    cv_d     = 1'b0;
    cbe_d    = '0;
    cdata_d  = '0;
    if (start_valid_i) begin
      active_d = 1'b1;
      kind_d   = start_kind;
      line_d   = (start_kind == KIND_WT) ? wt_start_line : start_line_i;
      mask_d   = (start_kind == KIND_PLAIN) ? '0 : start_mask_i;
      dirty_d  = (start_kind == KIND_WT);
      cached_d = 1'b0;
      memd_d   = 1'b0;
      sender_d = start_sender_i;
    end else if (active_q) begin
      if (fill_valid_i) begin
        memd_d = 1'b1;
        if (kind_q != KIND_WT && !dirty_q) begin
          line_d = fill_data_i;
        end
      end
      if (prb_valid_i) begin
        if (prb_hit_i) begin
          cached_d = 1'b1;
        end
        if (prb_dirty_i) begin
          if (kind_q == KIND_WT) begin
            line_d = prb_wt_line;
            mask_d = '1;
          end else if (!dirty_q) begin
            line_d   = prb_data_i;
            dirty_d  = 1'b1;
            sender_d = prb_sender_i;
          end else if (kind_q == KIND_PLAIN && prb_data_i != line_q) begin
            mism_d = 1'b1;
          end
        end
      end
      if (fin_valid_i) begin
        active_d = 1'b0;
        cv_d     = sel_valid;
        cbe_d    = sel_be;
        cdata_d  = sel_data;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      active_q <= 1'b0;
      kind_q   <= KIND_PLAIN;
      line_q   <= '0;
      mask_q   <= '0;
      dirty_q  <= 1'b0;
      cached_q <= 1'b0;
      memd_q   <= 1'b0;
      sender_q <= '0;
    end else if (ev_en) begin
      active_q <= active_d;
      kind_q   <= kind_d;
      line_q   <= line_d;
      mask_q   <= mask_d;
      dirty_q  <= dirty_d;
      cached_q <= cached_d;
      memd_q   <= memd_d;
      sender_q <= sender_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oper_q <= '0;
    end else if (oper_en) begin
      oper_q <= start_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mism_q  <= 1'b0;
      cv_q    <= 1'b0;
      cbe_q   <= '0;
      cdata_q <= '0;
    end else begin
      mism_q  <= mism_d;
      cv_q    <= cv_d;
      cbe_q   <= cbe_d;
      cdata_q <= cdata_d;
    end
  end

  assign active_o       = active_q;
  assign kind_o         = kind_q;
  assign line_o         = line_q;
  assign mask_o         = mask_q;
  assign dirty_o        = dirty_q;
  assign cached_o       = cached_q;
  assign memdata_o      = memd_q;
  assign sender_o       = sender_q;
  assign mismatch_o     = mism_q;
  assign commit_valid_o = cv_q;
  assign commit_be_o    = cbe_q;
  assign commit_data_o  = cdata_q;
endmodule

// File: rtl/lmu_checker.sv
module lmu_checker #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned SENDER_W   = 4,
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_valid_i,
  input logic                  fill_valid_i,
  input logic                  prb_valid_i,
  input logic                  prb_dirty_i,
  input logic                  prb_hit_i,
  input logic                  fin_valid_i,
  input logic                  active_o,
  input logic [1:0]            kind_o,
  input logic [LINE_W-1:0]     line_o,
  input logic [LINE_BYTES-1:0] mask_o,
  input logic                  dirty_o,
  input logic                  cached_o,
  input logic                  memdata_o,
  input logic                  mismatch_o,
  input logic                  commit_valid_o
);
  // events are taken to be mutually exclusive
  p_single_event_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_valid_i, fill_valid_i, prb_valid_i, fin_valid_i}));

  p_wt_fill_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && kind_o == 2'd1 && fill_valid_i |=> $stable(line_o));

  p_dirty_fill_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && dirty_o && fill_valid_i |=> $stable(line_o));

  p_fill_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && fill_valid_i |=> memdata_o);

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && kind_o == 2'd1 && prb_valid_i && prb_dirty_i |=> mask_o == '1);

  p_mismatch_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |-> $past(dirty_o && prb_valid_i && prb_dirty_i && kind_o == 2'd0));

  p_hit_cached_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && prb_valid_i && prb_hit_i |=> cached_o);

  p_clean_probe_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && prb_valid_i && !prb_dirty_i |=> $stable(line_o));

  p_dirty_plain_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && kind_o == 2'd0 && dirty_o && fin_valid_i |=> !commit_valid_o);

  p_idle_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o && !start_valid_i |=> $stable(line_o) && !active_o);

  p_commit_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid_o |-> $past(fin_valid_i));

  p_commit_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid_o && !fin_valid_i |=> !commit_valid_o);
endmodule

bind line_merge_unit lmu_checker #(
  .LINE_BYTES (LINE_BYTES),
  .SENDER_W   (SENDER_W)
) chk_i (.*);

// File: tb/line_merge_unit_tb_top.sv
module line_merge_unit_tb_top;
  localparam int NB = 64;
  localparam int LW = NB * 8;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic          start_valid_i, fill_valid_i, prb_valid_i, fin_valid_i;
  logic [1:0]    start_kind_i;
  logic [LW-1:0] start_line_i, start_data_i, fill_data_i, prb_data_i, fin_store_i;
  logic [NB-1:0] start_mask_i;
  logic [SW-1:0] start_sender_i, prb_sender_i;
  logic          prb_dirty_i, prb_hit_i;
  logic          active_o, dirty_o, cached_o, memdata_o, mismatch_o, commit_valid_o;
  logic [1:0]    kind_o;
  logic [LW-1:0] line_o, commit_data_o;
  logic [NB-1:0] mask_o, commit_be_o;
  logic [SW-1:0] sender_o;

  line_merge_unit #(.LINE_BYTES(NB), .SENDER_W(SW)) dut_i (.*);

  // reference model
  logic          m_act, m_dirty, m_cached, m_memd, m_mism, m_cv;
  logic [1:0]    m_kind;
  logic [LW-1:0] m_line, m_oper, m_cdata;
  logic [NB-1:0] m_mask, m_cbe;
  logic [SW-1:0] m_sender;

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] v;
    for (int w = 0; w < LW / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [LW-1:0] bmerge(logic [NB-1:0] sel, logic [LW-1:0] pick, logic [LW-1:0] base);
    logic [LW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = sel[b] ? pick[b*8 +: 8] : base[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [LW-1:0] batomic(logic [NB-1:0] m, logic [LW-1:0] st, logic [LW-1:0] op, logic [LW-1:0] kp);
    logic [LW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = m[b] ? 8'(st[b*8 +: 8] + op[b*8 +: 8]) : kp[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "active", LW'(active_o), LW'(m_act));
    chk(req, "kind", LW'(kind_o), LW'(m_kind));
    chk(req, "line", line_o, m_line);
    chk(req, "mask", LW'(mask_o), LW'(m_mask));
    chk(req, "dirty", LW'(dirty_o), LW'(m_dirty));
    chk(req, "cached", LW'(cached_o), LW'(m_cached));
    chk(req, "memdata", LW'(memdata_o), LW'(m_memd));
    chk(req, "sender", LW'(sender_o), LW'(m_sender));
    chk(req, "mismatch", LW'(mismatch_o), LW'(m_mism));
    chk(req, "commit_valid", LW'(commit_valid_o), LW'(m_cv));
    chk(req, "commit_be", LW'(commit_be_o), LW'(m_cbe));
    chk(req, "commit_data", commit_data_o, m_cdata);
  endtask

  task automatic step(string req);
    @(negedge clk);
    start_valid_i = 0; fill_valid_i = 0; prb_valid_i = 0; fin_valid_i = 0;
    compare_all(req);
  endtask

  task automatic clear_pulses();
    m_mism = 0; m_cv = 0; m_cbe = '0; m_cdata = '0;
  endtask

  task automatic ev_start(string req, logic [1:0] k, logic [LW-1:0] ln, logic [LW-1:0] dt,
                          logic [NB-1:0] mk, logic [SW-1:0] s);
    start_valid_i = 1; start_kind_i = k; start_line_i = ln; start_data_i = dt;
    start_mask_i = mk; start_sender_i = s;
    clear_pulses();
    m_act = 1; m_kind = (k == 2'd3) ? 2'd0 : k;
    m_line = (m_kind == 2'd1) ? bmerge(mk, dt, ln) : ln;
    m_mask = (m_kind == 2'd0) ? '0 : mk;
    m_dirty = (m_kind == 2'd1); m_cached = 0; m_memd = 0; m_sender = s; m_oper = dt;
    step(req);
  endtask

  task automatic ev_fill(string req, logic [LW-1:0] d);
    fill_valid_i = 1; fill_data_i = d;
    clear_pulses();
    if (m_act) begin
      m_memd = 1;
      if (m_kind != 2'd1 && !m_dirty) m_line = d;
    end
    step(req);
  endtask

  task automatic ev_probe(string req, logic [LW-1:0] d, logic dty, logic hit, logic [SW-1:0] s);
    prb_valid_i = 1; prb_data_i = d; prb_dirty_i = dty; prb_hit_i = hit; prb_sender_i = s;
    clear_pulses();
    if (m_act) begin
      if (hit) m_cached = 1;
      if (dty) begin
        if (m_kind == 2'd1) begin
          m_line = bmerge(m_mask, m_line, d); m_mask = '1;
        end else if (!m_dirty) begin
          m_line = d; m_dirty = 1; m_sender = s;
        end else if (m_kind == 2'd0 && d != m_line) begin
          m_mism = 1;
        end
      end
    end
    step(req);
  endtask

  task automatic ev_fin(string req, logic [LW-1:0] st);
    fin_valid_i = 1; fin_store_i = st;
    clear_pulses();
    if (m_act) begin
      m_act = 0;
      if (m_kind == 2'd1) begin
        m_cv = 1; m_cbe = m_mask; m_cdata = m_line;
      end else if (m_kind == 2'd2) begin
        m_cv = 1; m_cbe = '1; m_cdata = batomic(m_mask, st, m_oper, m_line);
      end else if (!m_dirty) begin
        m_cv = 1; m_cbe = '1; m_cdata = m_line;
      end
    end
    step(req);
  endtask

  task automatic ev_idle(string req);
    clear_pulses();
    step(req);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [LW-1:0] a, b;
    void'($urandom(32'd20240611));
    start_valid_i = 0; fill_valid_i = 0; prb_valid_i = 0; fin_valid_i = 0;
    start_kind_i = 0; start_line_i = '0; start_data_i = '0; start_mask_i = '0;
    start_sender_i = '0; fill_data_i = '0; prb_data_i = '0; prb_dirty_i = 0;
    prb_hit_i = 0; prb_sender_i = '0; fin_store_i = '0;
    m_act = 0; m_kind = 0; m_line = '0; m_mask = '0; m_dirty = 0; m_cached = 0;
    m_memd = 0; m_sender = '0; m_oper = '0; clear_pulses();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all("R12");

    // R11: events without an open transaction
    ev_fill("R11", rand_line());
    ev_probe("R11", rand_line(), 1, 1, 4'd3);
    ev_fin("R11", rand_line());

    // R1/R2/R3/R4/R8: write-through path
    a = rand_line(); b = rand_line();
    ev_start("R1", 2'd1, a, b, 64'h0000_0000_0000_00F0, 4'd5);
    ev_fill("R2", rand_line());
    chk("R3", "memdata", LW'(memdata_o), LW'(1));
    ev_probe("R4", rand_line(), 1, 0, 4'd9);
    chk("R4", "mask", LW'(mask_o), {{(LW-NB){1'b0}}, {NB{1'b1}}});
    ev_fin("R8", rand_line());
    ev_idle("R13");

    // R5/R6/R7/R10: plain path
    a = rand_line();
    ev_start("R1", 2'd3, a, rand_line(), '1, 4'd2);
    ev_probe("R7", rand_line(), 0, 1, 4'd7);
    chk("R7", "line", line_o, a);
    b = rand_line();
    ev_probe("R5", b, 1, 0, 4'd11);
    ev_probe("R6", b, 1, 0, 4'd12);
    ev_probe("R6", rand_line(), 1, 0, 4'd12);
    chk("R6", "mismatch", LW'(mismatch_o), LW'(1));
    ev_fill("R2", rand_line());
    ev_fin("R10", rand_line());
    chk("R10", "commit_valid", LW'(commit_valid_o), LW'(0));
    ev_start("R1", 2'd0, a, b, '0, 4'd1);
    ev_fin("R10", rand_line());

    // R9: atomic with wrapping add
    ev_start("R1", 2'd2, {NB{8'h11}}, {NB{8'h02}}, 64'h0F, 4'd6);
    ev_fin("R9", {NB{8'hFF}});
    chk("R9", "atomic literal", commit_data_o, {{(NB-4){8'h11}}, {4{8'h01}}});
    chk("R9", "atomic be", LW'(commit_be_o), {{(LW-NB){1'b0}}, {NB{1'b1}}});
    ev_start("R1", 2'd2, rand_line(), rand_line(), 64'hFF00, 4'd4);
    ev_probe("R5", rand_line(), 1, 1, 4'd8);
    ev_probe("R6", rand_line(), 1, 0, 4'd10);
    ev_fin("R9", rand_line());

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom % 10;
      case (r)
        0, 1: ev_start("R1", 2'($urandom), rand_line(), rand_line(),
                       {$urandom, $urandom}, 4'($urandom));
        2, 3: ev_fill("R2", rand_line());
        4, 5, 6: ev_probe(m_kind == 2'd1 ? "R4" : "R5",
                          ($urandom % 2) ? m_line : rand_line(),
                          1'($urandom), 1'($urandom), 4'($urandom));
        7: ev_fin("R13", rand_line());
        default: ev_idle("R11");
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule